// File: doc/BRIEF.md
# CCM Header and Counter Block Generator

This block feeds an 8-bit block cipher with the two kinds of formatting block that CCM mode needs: the first authentication block B0 and the counter blocks CTRi. It keeps a 13-byte nonce, a payload length and a block index. On a one-cycle request it emits 16 bytes on 16 consecutive cycles. Each block starts with a flag byte, then carries the nonce, then a two-byte field. That field holds the payload length for B0 and the block index for a counter block.

The nonce is loaded one byte per cycle, first byte first, and is kept in a ring that turns once per emitted block, so it is never reloaded between blocks. The index starts at zero after reset and after a clear. It steps by one after each counter block, so the first counter block after a clear is CTR0, used for tag encryption, and payload blocks follow from CTR1. Associated-data formatting and the cipher itself lie outside the block.

Top module: `ccm_blkgen`

## Requirements
- R1: After reset `busy`, `out_valid` and `out_last` are 0 and the block index is 0, so the first counter block carries field value 0.
- R2: A request accepted while idle makes `out_valid` high for exactly 16 consecutive cycles, starting the cycle after the request edge. `out_last` is high only on the 16th byte.
- R3: Byte 0 is the flag byte: 0x09 for B0 (4-byte tag, two-byte length field, no associated data) and 0x01 for a counter block.
- R4: Bytes 1 to 13 are the nonce bytes in the order they were loaded. The nonce is the same in every later block until it is reloaded.
- R5: In B0, bytes 14 and 15 are the 16-bit payload length, most significant byte first. The length is taken from `len_val` on an idle cycle with `len_ld` high.
- R6: In a counter block, bytes 14 and 15 are the index, most significant byte first. The index rises by one after each counter block and is not changed by a B0 block.
- R7: `ctr_clr` on an idle cycle sets the index to 0. When it comes in the same cycle as `req_ctr`, that counter block carries index 0.
- R8: When `req_b0` and `req_ctr` are both high on an idle cycle, only a B0 block is emitted and the index is not changed.
- R9: While `busy` is high, requests, nonce loads, length loads and index clears are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nonce_ld | input | 1 | Shift `nonce_byte` into the nonce ring (idle only) |
| nonce_byte | input | 8 | Nonce byte to load |
| len_ld | input | 1 | Capture `len_val` as the payload length (idle only) |
| len_val | input | 16 | Payload length in bytes |
| ctr_clr | input | 1 | Reset the block index to 0 (idle only) |
| req_b0 | input | 1 | Request a B0 block |
| req_ctr | input | 1 | Request a counter block |
| busy | output | 1 | A block is being emitted |
| out_valid | output | 1 | `out_byte` carries a block byte |
| out_byte | output | 8 | Block byte |
| out_last | output | 1 | Final byte of the block |

## Verification
Two pairs of events can land on the same idle cycle: an index clear together with a counter request, and a B0 request together with a counter request. The bench drives each pair on one edge. It judges the first by the index bytes of the block that follows. It judges the second by the flag byte, and by the index value the next counter block carries. A scoreboard holds every expected byte, so a block that should not appear shows up as an unexpected `out_valid`.

// File: rtl/ccm_blkgen_pkg.sv
package ccm_blkgen_pkg;

  typedef enum logic {
    KIND_B0  = 1'b0,
    KIND_CTR = 1'b1
  } blk_kind_e;

  // flag byte of the first authentication block, no associated data
  function automatic logic [7:0] b0_flag(int tag_bytes, int len_bytes);
    return 8'((((tag_bytes - 2) / 2) << 3) | (len_bytes - 1));
  endfunction

  // flag byte of a counter block
  function automatic logic [7:0] ctr_flag(int len_bytes);
    return 8'(len_bytes - 1);
  endfunction

  // byte idx (0 = most significant) of a len_bytes-wide field
  function automatic logic [7:0] field_byte(logic [63:0] val, int idx, int len_bytes);
    return 8'(val >> (8 * (len_bytes - 1 - idx)));
  endfunction

endpackage

// File: rtl/ccm_nonce_ring.sv
module ccm_nonce_ring #(
  parameter int NB = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [7:0] ld_byte,
  input  logic       rot,
  output logic [7:0] head
);

  logic [7:0] q [NB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NB; k++) q[k] <= '0;
    end else if (ld) begin
      for (int k = 0; k < NB - 1; k++) q[k] <= q[k + 1];
      q[NB - 1] <= ld_byte;
    end else if (rot) begin
      for (int k = 0; k < NB - 1; k++) q[k] <= q[k + 1];
      q[NB - 1] <= q[0];
    end
  end

  assign head = q[0];

  AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld && !rot |=> $stable(head)); // R9
  AST_RING_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld || rot) |=> head == $past(q[1])); // R4

endmodule

// File: rtl/ccm_blk_index.sv
module ccm_blk_index #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [FW-1:0] idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (clr)  idx <= '0;
    else if (step) idx <= idx + FW'(1);
  end

  AST_IDX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> idx == '0); // R7
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clr |=> idx == $past(idx) + FW'(1)); // R6
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !clr |=> $stable(idx)); // R6

endmodule

// File: rtl/ccm_blk_seq.sv
module ccm_blk_seq
  import ccm_blkgen_pkg::*;
#(
  parameter int BLK = 16,
  parameter int NB  = 13,
  localparam int PW = $clog2(BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_b0,
  input  logic          req_ctr,
  output logic          busy,
  output logic [PW-1:0] pos,
  output blk_kind_e     kind,
  output logic          ev_start,
  output logic          ev_last,
  output logic          ev_rot
);

  blk_kind_e kind_nxt;

  assign ev_start = !busy && (req_b0 || req_ctr);
  assign kind_nxt = req_b0 ? KIND_B0 : KIND_CTR;
  assign ev_last  = busy && (pos == PW'(BLK - 1));
  assign ev_rot   = busy && (pos >= PW'(1)) && (pos <= PW'(NB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pos  <= '0;
      kind <= KIND_B0;
    end else if (ev_start) begin
      busy <= 1'b1;
      pos  <= '0;
      kind <= kind_nxt;
    end else if (busy) begin
      if (ev_last) busy <= 1'b0;
      pos <= pos + PW'(1);
    end
  end

  AST_START: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> busy && pos == '0); // R2
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ev_last |=> busy && pos == $past(pos) + PW'(1)); // R2
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> !busy); // R2
  AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ev_last |=> $stable(kind)); // R9
  AST_B0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start && req_b0 |=> kind == KIND_B0); // R8

endmodule

// File: rtl/ccm_blkgen.sv
module ccm_blkgen
  import ccm_blkgen_pkg::*;
#(
  parameter int NONCE_BYTES = 13,
  parameter int TAG_BYTES   = 4,
  localparam int BLK        = 16,
  localparam int LEN_BYTES  = BLK - 1 - NONCE_BYTES,
  localparam int FW         = 8 * LEN_BYTES,
  localparam int PW         = $clog2(BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nonce_ld,
  input  logic [7:0]    nonce_byte,
  input  logic          len_ld,
  input  logic [FW-1:0] len_val,
  input  logic          ctr_clr,
  input  logic          req_b0,
  input  logic          req_ctr,
  output logic          busy,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  output logic          out_last
);

  localparam logic [7:0] FLAG_B0  = b0_flag(TAG_BYTES, LEN_BYTES);
  localparam logic [7:0] FLAG_CTR = ctr_flag(LEN_BYTES);

  logic [PW-1:0] pos;
  blk_kind_e     kind;
  logic          ev_start, ev_last, ev_rot, ev_ctr_end;
  logic          ring_ld, idx_clr;
  logic [7:0]    head;
  logic [FW-1:0] idx, len_q, fld;

  ccm_blk_seq #(.BLK(BLK), .NB(NONCE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_b0(req_b0), .req_ctr(req_ctr),
    .busy(busy), .pos(pos), .kind(kind),
    .ev_start(ev_start), .ev_last(ev_last), .ev_rot(ev_rot)
  );

  assign ring_ld = nonce_ld && !busy;

  ccm_nonce_ring #(.NB(NONCE_BYTES)) u_ring (
    .clk(clk), .rst_n(rst_n), .ld(ring_ld), .ld_byte(nonce_byte),
    .rot(ev_rot), .head(head)
  );

  assign idx_clr    = ctr_clr && !busy;
  assign ev_ctr_end = ev_last && (kind == KIND_CTR);

  ccm_blk_index #(.FW(FW)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(idx_clr), .step(ev_ctr_end), .idx(idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                len_q <= '0;
    else if (len_ld && !busy)  len_q <= len_val;
  end

  assign fld = (kind == KIND_CTR) ? idx : len_q;

  always_comb begin
    if (!busy)                          out_byte = '0;
    else if (pos == '0)                 out_byte = (kind == KIND_CTR) ? FLAG_CTR : FLAG_B0;
    else if (pos <= PW'(NONCE_BYTES))   out_byte = head;
    else out_byte = field_byte(64'(fld), int'(pos) - 1 - NONCE_BYTES, LEN_BYTES);
  end

  assign out_valid = busy;
  assign out_last  = ev_last;

  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(len_q)); // R9
  AST_FLAG_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && pos == '0 |-> out_byte == ((kind == KIND_CTR) ? 8'h01 : 8'h09)); // R3
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R2

endmodule

// File: tb/ccm_blkgen_tb.sv
module ccm_blkgen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nonce_ld = 1'b0, len_ld = 1'b0, ctr_clr = 1'b0;
  logic        req_b0 = 1'b0, req_ctr = 1'b0;
  logic [7:0]  nonce_byte = '0;
  logic [15:0] len_val = '0;
  logic        busy, out_valid, out_last;
  logic [7:0]  out_byte;

  always #2 clk = ~clk;

  ccm_blkgen u_dut (
    .clk(clk), .rst_n(rst_n), .nonce_ld(nonce_ld), .nonce_byte(nonce_byte),
    .len_ld(len_ld), .len_val(len_val), .ctr_clr(ctr_clr),
    .req_b0(req_b0), .req_ctr(req_ctr), .busy(busy),
    .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last)
  );

  int total = 0;
  int bad = 0;
  logic [8:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] mdl_nonce [13];
  int         mdl_len = 0;
  int         mdl_i = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_block(bit is_ctr, int fld, string tag);
    exp_q.push_back({1'b0, is_ctr ? 8'h01 : 8'h09}); tag_q.push_back({"R3 flag ", tag});
    for (int k = 0; k < 13; k++) begin
      exp_q.push_back({1'b0, mdl_nonce[k]}); tag_q.push_back({"R4 nonce ", tag});
    end
    exp_q.push_back({1'b0, 8'(fld >> 8)});
    tag_q.push_back({is_ctr ? "R6 field hi " : "R5 field hi ", tag});
    exp_q.push_back({1'b1, 8'(fld)});
    tag_q.push_back({is_ctr ? "R6 field lo " : "R5 field lo ", tag});
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected byte", int'(out_byte), 0);
      end else begin
        automatic logic [8:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(out_byte == e[7:0], t, int'(out_byte), int'(e[7:0]));
        chk(out_last == e[8], {"R2 last ", t}, int'(out_last), int'(e[8]));
      end
    end
  end

  task automatic load_nonce(int seed);
    for (int k = 0; k < 13; k++) begin
      mdl_nonce[k] = 8'(seed + 37 * k);
      nonce_ld = 1'b1; nonce_byte = mdl_nonce[k];
      @(negedge clk);
    end
    nonce_ld = 1'b0;
  endtask

  task automatic load_len(int v);
    mdl_len = v; len_ld = 1'b1; len_val = 16'(v);
    @(negedge clk);
    len_ld = 1'b0;
  endtask

  // one block; poke drives every ignored stimulus mid-block (R9)
  task automatic run_block(bit b0, bit ctr, bit clr, bit poke, string tag);
    if (b0) push_block(1'b0, mdl_len, tag);
    else begin
      if (clr) mdl_i = 0;
      push_block(1'b1, mdl_i, tag);
      mdl_i = (mdl_i + 1) & 16'hffff;
    end
    req_b0 = b0; req_ctr = ctr; ctr_clr = clr;
    @(negedge clk);
    req_b0 = 1'b0; req_ctr = 1'b0; ctr_clr = 1'b0;
    chk(busy == 1'b1, {"R2 busy ", tag}, int'(busy), 1);
    for (int k = 0; k < 16; k++) begin
      if (poke && k == 4) begin
        nonce_ld = 1'b1; nonce_byte = 8'hee; len_ld = 1'b1; len_val = 16'hbeef;
        ctr_clr = 1'b1; req_b0 = 1'b1; req_ctr = 1'b1;
      end else begin
        nonce_ld = 1'b0; len_ld = 1'b0; ctr_clr = 1'b0; req_b0 = 1'b0; req_ctr = 1'b0;
      end
      @(negedge clk);
    end
    chk(busy == 1'b0 && exp_q.size() == 0, {"R2 end ", tag}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0 && out_last == 1'b0, "R1 after reset",
        int'({busy, out_valid, out_last}), 0);

    load_nonce(8'h10);
    load_len(32);
    run_block(1, 0, 0, 0, "b0 first");
    run_block(0, 1, 0, 0, "R1 ctr0 after reset");
    run_block(0, 1, 0, 0, "ctr1");
    run_block(1, 0, 0, 0, "b0 repeat nonce");
    run_block(0, 1, 0, 0, "ctr2 after b0");
    run_block(0, 1, 1, 0, "R7 clear with request");
    run_block(0, 1, 0, 0, "ctr1 after clear");
    run_block(1, 1, 0, 0, "R8 both requests");
    run_block(0, 1, 0, 0, "R8 index untouched");
    run_block(0, 1, 0, 1, "R9 poke during ctr");
    run_block(1, 0, 0, 0, "R9 b0 after poke");
    run_block(0, 1, 0, 0, "R9 index after poke");
    load_nonce(8'hc3);
    load_len(16'h1234);
    run_block(1, 0, 0, 0, "b0 new nonce and length");
    ctr_clr = 1'b1; @(negedge clk); ctr_clr = 1'b0;
    mdl_i = 0;
    run_block(0, 1, 0, 0, "R7 clear alone");
    run_block(0, 1, 0, 0, "ctr after lone clear");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule